// File: doc/BRIEF.md
# Fuse Controller Register Front-End with Passcode Write Lock

This block is the bus-facing register set of a fuse controller. It holds a write-lock register that must be loaded with a 16-bit passcode before any other register can be changed. Until that happens, every write elsewhere in the map is silently discarded.

It also holds an interrupt group made of four registers:

- a status register whose bits are set by single-cycle pulses from the controller core and cleared by software writing ones;
- a mask register that the bus can read but not write;
- an enable strobe that clears mask bits;
- a disable strobe that sets mask bits.

A single level interrupt line is raised while any status bit is set whose mask bit is clear.

Accesses are whole 32-bit words on a simple bus: a write strobe with address and data, and a combinational read path selected by the address. Core events arrive on a 32-bit pulse vector. Bit 0 means program done, bit 1 program error, bit 2 read done and bit 3 read error. Bits 4 to 14 and bit 31 are further event sources, and bits 15 to 30 are reserved.

Register offsets (byte addresses):

| Offset | Register |
|---|---|
| 0x00 | write lock |
| 0x04 | status |
| 0x08 | mask |
| 0x0C | enable strobe |
| 0x10 | disable strobe |

Any other address, including one with address bits [1:0] not zero, is unmapped.

Top module: `fuse_regfront`

## Requirements
- R1: After reset, `locked` is 1 and the lock register reads 1. Status reads 0, mask reads 0x80007FFF and `irq` is 0.
- R2: A write to offset 0x00 is always accepted. If the data is exactly 0x0000DF0D, the lock becomes 0 and reads 0. Any other data value, such as 0x0001DF0D, sets the lock to 1.
- R3: While the lock is 1, a write to any offset other than 0x00 changes no status or mask bit.
- R4: While unlocked, writing a 1 to status bits 0 to 14 or bit 31 at offset 0x04 clears them. Status bits 15 to 30 always read 0, even when their event pulse is given.
- R5: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: While unlocked, a 1 written to offset 0x0C clears that mask bit, and a 1 written to offset 0x10 sets it. Both offsets read 0.
- R7: A write to the mask offset 0x08 leaves the mask unchanged.
- R8: `irq` is 1 exactly when some status bit is 1 while its mask bit is 0. It follows the registers in the same cycle they update.
- R9: Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 32 | Single-cycle event pulses setting status bits |
| irq | output | 1 | Level interrupt |
| locked | output | 1 | Current write-lock state |

## Verification
An event pulse from the core and a bus write that clears status can land in the same cycle on the same bit. The bench provokes this both directly and by mixing random clear writes with random pulse vectors in one cycle. The bench expects the set to win. It also checks that the lock state read back in that same cycle still decides whether the clear counts at all.

// File: rtl/fuse_regfront.sv
module fuse_regfront #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] PASSCODE = 32'h0000_DF0D,
  parameter logic [31:0] SRC_MASK = 32'h8000_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_set,
  output logic              irq,
  output logic              locked
);
  localparam logic [ADDR_W-1:0] OFS_LOCK = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_DIS  = ADDR_W'(8'h10);

  logic        lock_q;
  logic [31:0] status_q, mask_q;

  wire wr_ok   = bus_wr && !lock_q;
  wire wr_lock = bus_wr && bus_addr == OFS_LOCK;
  wire wr_stat = wr_ok && bus_addr == OFS_STAT;
  wire wr_en   = wr_ok && bus_addr == OFS_EN;
  wire wr_dis  = wr_ok && bus_addr == OFS_DIS;

  wire [31:0] clr_bits = wr_stat ? bus_wdata : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b1;
      status_q <= '0;
      mask_q   <= SRC_MASK;
    end else begin
      if (wr_lock) lock_q <= (bus_wdata != PASSCODE);
      status_q <= ((status_q & ~clr_bits) | evt_set) & SRC_MASK;
      if (wr_en)       mask_q <= mask_q & ~bus_wdata;
      else if (wr_dis) mask_q <= (mask_q | bus_wdata) & SRC_MASK;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_LOCK: bus_rdata = {31'b0, lock_q};
      OFS_STAT: bus_rdata = status_q;
      OFS_MASK: bus_rdata = mask_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq    = |(status_q & ~mask_q);
  assign locked = lock_q;
endmodule

// File: rtl/fuse_regfront_chk.sv
module fuse_regfront_chk #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] PASSCODE = 32'h0000_DF0D,
  parameter logic [31:0] SRC_MASK = 32'h8000_7FFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       evt_set,
  input logic              irq,
  input logic              locked,
  input logic [31:0]       status_q,
  input logic [31:0]       mask_q
);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(8'h10);

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LOCK && bus_wdata == PASSCODE) |=> !locked);

  assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LOCK && bus_wdata != PASSCODE) |=> locked);

  assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && bus_addr != A_LOCK) |=> $stable(mask_q));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_wr && bus_addr == A_STAT && bus_wdata[0] && !evt_set[0])
      |=> !status_q[0]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set[0] |=> status_q[0]);

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_set & SRC_MASK & ~mask_q)) && !(bus_wr && bus_addr == A_DIS)) |=> irq);
endmodule

bind fuse_regfront fuse_regfront_chk #(
  .ADDR_W(ADDR_W), .PASSCODE(PASSCODE), .SRC_MASK(SRC_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .evt_set(evt_set), .irq(irq), .locked(locked),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/fuse_regfront_tb.sv
`timescale 1ns/1ps
module fuse_regfront_tb;
  localparam logic [31:0] PASS  = 32'h0000_DF0D;
  localparam logic [31:0] VALID = 32'h8000_7FFF;

  logic        clk = 0, rst_n = 0, bus_wr = 0, irq, locked;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, evt_set = 0;
  int n_chk = 0, n_bad = 0;
  logic        m_lk;
  logic [31:0] m_st, m_mk;

  always #2 clk = ~clk;

  fuse_regfront u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set), .irq(irq),
    .locked(locked));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(logic wr, logic [7:0] a, logic [31:0] d, logic [31:0] ev);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = ev;
    @(negedge clk);
    bus_wr = 0; evt_set = 0;
    if (wr) begin
      if (a == 8'h00) m_lk = (d != PASS);
      else if (!m_lk) begin
        if (a == 8'h04) m_st = m_st & ~d;
        else if (a == 8'h0C) m_mk = m_mk & ~d;
        else if (a == 8'h10) m_mk = (m_mk | d) & VALID;
      end
    end
    m_st = (m_st | ev) & VALID;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic check_all(string tag);
    rd({tag, " R2 lock"}, 8'h00, {31'b0, m_lk});
    rd({tag, " R4 status"}, 8'h04, m_st);
    rd({tag, " R6 mask"}, 8'h08, m_mk);
    check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, |(m_st & ~m_mk)});
    check({tag, " R2 locked"}, {31'b0, locked}, {31'b0, m_lk});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    m_lk = 1; m_st = 0; m_mk = VALID;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    cyc(1, 8'h00, 32'h0001_DF0D, 0); check_all("R2 near passcode");
    cyc(1, 8'h0C, 32'hFFFF_FFFF, 0); check_all("R3 locked enable dropped");
    cyc(0, 8'h00, 0, 32'h1);
    cyc(1, 8'h04, 32'h1, 0);         check_all("R3 locked clear dropped");
    cyc(1, 8'h00, PASS, 0);          check_all("R2 unlock");
    cyc(1, 8'h0C, 32'h1, 0);         check_all("R6 enable bit0 R8 irq");
    cyc(1, 8'h04, 32'h1, 32'h1);     check_all("R5 set wins");
    cyc(1, 8'h04, 32'h1, 0);         check_all("R4 clear");
    cyc(0, 8'h00, 0, 32'h0010_0008); check_all("R4 reserved bit20");
    cyc(1, 8'h08, 32'h0, 0);         check_all("R7 mask write ignored");
    cyc(1, 8'h0C, 32'h8000_0008, 0); check_all("R8 irq via bit3");
    cyc(1, 8'h10, 32'h8, 0);         check_all("R6 disable");
    rd("R6 enable reads 0", 8'h0C, 0);
    rd("R6 disable reads 0", 8'h10, 0);
    rd("R9 unmapped", 8'h40, 0);
    rd("R9 misaligned", 8'h05, 0);
    cyc(1, 8'h05, 32'hFFFF_FFFF, 0); check_all("R9 misaligned write");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d, ev;
      logic [7:0]  a;
      int k;
      k = $urandom % 8;
      a = (k == 0) ? 8'h00 : (k < 6) ? 8'(4 * (k - 1)) : 8'h04;
      d = $urandom;
      if (a == 8'h00 && ($urandom % 2 == 0)) d = PASS;
      ev = ($urandom % 2) ? $urandom : 32'h0;
      cyc($urandom % 4 != 0, a, d, ev);
      check_all("R5 random");
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule